// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block tracks sixteen software-generated interrupts for a cluster of up to eight processors. Each processor owns a private copy of every interrupt. Each copy holds a pending latch and an 8-bit source mask, which records which processors asked for that interrupt to be raised on that processor.

A processor raises an interrupt by writing the generation word on a shared register bus, with its own index on `bus_cpu`. A filter mode in that word picks the targets:

- the explicit target list,
- every online processor except the writer, or
- the writer alone.

Software can also inspect and edit the source masks of the accessing processor's copies through two byte-addressed banks. One bank sets bits in a mask and the other removes them. An entry stays pending until its mask is empty. The per-processor pending state leaves the block as a flat vector and as one summary line per processor.

Top module: `sgi_dispatch`

## Requirements
- R1: A write to the generation word (byte address 0x00 to 0x03) takes the interrupt ID from data bits [3:0], the target list from bits [23:16] (bit n names processor n) and the filter mode from bits [25:24]. In mode 0 the listed processors are targeted, but target bits for processor numbers at or above `online_cnt` are ignored.
- R2: In mode 1 every processor below `online_cnt` is targeted except the writer, and the target list is ignored.
- R3: In mode 2 only the writer is targeted, whatever the target list holds.
- R4: A generation write with mode 3 changes no pending latch and no source mask.
- R5: For each target of a generation write, the entry for that target and ID gets the writer's bit (bit `bus_cpu`) ORed into its source mask, and its pending latch is set.
- R6: A write to the set bank (byte addresses 0x20 to 0x2F, where offset = ID) ORs the written byte into that ID's source mask. The entry becomes pending if the mask is then nonzero. A zero byte changes nothing.
- R7: A write to the clear bank (byte addresses 0x10 to 0x1F, where offset = ID) removes the written bits from the mask. The pending latch clears only when the mask becomes zero.
- R8: Reads of either bank return source masks. Reads of the generation word and of unmapped addresses (0x04 to 0x0F, 0x30 to 0x3F) return zero. Writes to unmapped addresses have no effect.
- R9: With `bus_wide` low, an access moves one byte on data bits [7:0], and read bits [31:8] are zero. With `bus_wide` high, the access covers four IDs starting at the address with its low two bits cleared, with the lowest ID in bits [7:0].
- R10: Bank reads and writes act only on the copies owned by processor `bus_cpu`, and the copies of other processors are untouched.
- R11: `pend_vec` bit `c*16+id` is the pending latch of processor c for that ID, and `cpu_irq[c]` is the OR of processor c's 16 latches.
- R12: Reset clears every pending latch and every source mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| online_cnt | input | 4 | Number of online processors, 1 to 8, static |
| bus_cpu | input | 3 | Processor performing the access |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 6 | Byte address |
| bus_wide | input | 1 | 1 = 32-bit access, 0 = 8-bit access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr`, `bus_cpu` and `bus_wide` |
| pend_vec | output | 128 | Pending latch per processor and ID |
| cpu_irq | output | 8 | Any-pending summary per processor |

## Verification
Some properties are checked on every cycle:

- every pending latch agrees with whether its mask is empty,
- a reserved-mode write leaves all pending state frozen,
- an unmapped write leaves all pending state frozen,
- a mode-1 write never touches the writer's own entry,
- a mode-2 write always raises the writer's summary line,
- reads of the generation word and narrow reads carry zero where required.

Target filtering against the online count, the accumulation of several sources in one mask, partial clears that keep an entry pending, byte-lane placement on wide accesses and the isolation between processor copies depend on particular sequences. Only the bench's scenarios show those.

// File: rtl/sgi_dispatch.sv
module sgi_dispatch #(
  parameter int NUM_CPUS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [3:0]                online_cnt,
  input  logic [$clog2(NUM_CPUS)-1:0] bus_cpu,
  input  logic                      bus_wr,
  input  logic [5:0]                bus_addr,
  input  logic                      bus_wide,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  output logic [NUM_CPUS*16-1:0]    pend_vec,
  output logic [NUM_CPUS-1:0]       cpu_irq
);
  localparam int NUM_IDS = 16;
  localparam int IDW     = $clog2(NUM_IDS);
  localparam int CPW     = $clog2(NUM_CPUS);
  localparam int ENTRIES = NUM_CPUS * NUM_IDS;

  logic [7:0]          src_q [ENTRIES];
  logic [ENTRIES-1:0]  pend_q;

  logic                gen_we, set_we, clr_we;
  logic [IDW-1:0]      gen_id;
  logic [1:0]          gen_mode;
  logic [NUM_CPUS-1:0] online_mask, req_onehot, tgt;
  logic [7:0]          req_mask;

  assign gen_we   = bus_wr && (bus_addr[5:2] == 4'd0);
  assign clr_we   = bus_wr && (bus_addr[5:4] == 2'b01);
  assign set_we   = bus_wr && (bus_addr[5:4] == 2'b10);
  assign gen_id   = bus_wdata[IDW-1:0];
  assign gen_mode = bus_wdata[25:24];
  assign req_onehot = NUM_CPUS'(1) << bus_cpu;
  assign req_mask   = 8'(1) << bus_cpu;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_online
    assign online_mask[c] = (4'(c) < online_cnt);
  end

  always_comb begin
    case (gen_mode)
      2'd0:    tgt = bus_wdata[16 +: NUM_CPUS] & online_mask;
      2'd1:    tgt = online_mask & ~req_onehot;
      2'd2:    tgt = req_onehot;
      default: tgt = '0;
    endcase
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    for (genvar i = 0; i < NUM_IDS; i++) begin : g_id
      localparam int K    = c * NUM_IDS + i;
      localparam int LANE = i % 4;
      logic       own, lane_hit, gen_hit;
      logic [7:0] wbyte, set_val, clr_val;

      assign own      = (bus_cpu == CPW'(c));
      assign lane_hit = bus_wide ? (bus_addr[3:2] == 2'(i / 4))
                                 : (bus_addr[3:0] == 4'(i));
      assign gen_hit  = gen_we && tgt[c] && (gen_id == IDW'(i));
      assign wbyte    = bus_wide ? bus_wdata[8*LANE +: 8] : bus_wdata[7:0];
      assign set_val  = src_q[K] | wbyte;
      assign clr_val  = src_q[K] & ~wbyte;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          src_q[K]  <= '0;
          pend_q[K] <= 1'b0;
        end else if (gen_hit) begin
          src_q[K]  <= src_q[K] | req_mask;
          pend_q[K] <= 1'b1;
        end else if (set_we && own && lane_hit) begin
          src_q[K] <= set_val;
          if (set_val != 8'd0) pend_q[K] <= 1'b1;
        end else if (clr_we && own && lane_hit) begin
          src_q[K] <= clr_val;
          if (clr_val == 8'd0) pend_q[K] <= 1'b0;
        end
      end
    end

    assign cpu_irq[c] = |pend_q[c*NUM_IDS +: NUM_IDS];
  end

  logic [31:0] bank_rd;
  always_comb begin
    bank_rd = '0;
    for (int j = 0; j < 4; j++) begin
      logic [IDW-1:0]     idx;
      logic [CPW+IDW-1:0] k;
      idx = bus_wide ? {bus_addr[3:2], 2'(j)} : bus_addr[3:0];
      k   = {bus_cpu, idx};
      if (bus_wide || j == 0) bank_rd[8*j +: 8] = src_q[k];
    end
  end

  assign bus_rdata = (bus_addr[5:4] == 2'b01 || bus_addr[5:4] == 2'b10) ? bank_rd : 32'd0;
  assign pend_vec  = pend_q;
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
  parameter int NUM_CPUS = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [$clog2(NUM_CPUS)-1:0] bus_cpu,
  input logic                        bus_wr,
  input logic [5:0]                  bus_addr,
  input logic                        bus_wide,
  input logic [31:0]                 bus_wdata,
  input logic [31:0]                 bus_rdata,
  input logic [NUM_CPUS*16-1:0]      pend_vec,
  input logic [NUM_CPUS-1:0]         cpu_irq,
  input logic [7:0]                  src_q [NUM_CPUS*16]
);
  localparam int ENTRIES = NUM_CPUS * 16;
  localparam int KW      = $clog2(ENTRIES);

  logic gen_wr;
  assign gen_wr = bus_wr && (bus_addr[5:2] == 4'd0);

  logic          m1_q, m1_prev_q;
  logic [KW-1:0] m1_idx_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m1_q      <= 1'b0;
      m1_prev_q <= 1'b0;
      m1_idx_q  <= '0;
    end else begin
      m1_q      <= gen_wr && (bus_wdata[25:24] == 2'd1);
      m1_idx_q  <= {bus_cpu, bus_wdata[3:0]};
      m1_prev_q <= pend_vec[{bus_cpu, bus_wdata[3:0]}];
    end
  end

  assert_excl_self_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m1_q |-> pend_vec[m1_idx_q] == m1_prev_q);

  assert_self_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gen_wr && bus_wdata[25:24] == 2'd2 |=> cpu_irq[$past(bus_cpu)]);

  assert_reserved_noop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gen_wr && bus_wdata[25:24] == 2'd3 |=> $stable(pend_vec));

  assert_gen_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr[5:2] == 4'd0 |-> bus_rdata == 32'd0);

  assert_unmapped_wr_noop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && (bus_addr[5:4] == 2'b11 || (bus_addr[5:4] == 2'b00 && bus_addr[3:2] != 2'b00))
    |=> $stable(pend_vec));

  assert_narrow_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wide |-> bus_rdata[31:8] == 24'd0);

  for (genvar k = 0; k < ENTRIES; k++) begin : g_ent
    assert_pend_tracks_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pend_vec[k] == (src_q[k] != 8'd0));
  end
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NUM_CPUS(NUM_CPUS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_cpu(bus_cpu), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wide(bus_wide), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .pend_vec(pend_vec), .cpu_irq(cpu_irq),
  .src_q(src_q)
);

// File: tb/sgi_dispatch_tb.sv
`timescale 1ns/1ps
module sgi_dispatch_tb;
  logic         clk = 0, rst_n = 0;
  logic [3:0]   online_cnt = 4'd4;
  logic [2:0]   bus_cpu = '0;
  logic         bus_wr = 0, bus_wide = 0;
  logic [5:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0, bus_rdata;
  logic [127:0] pend_vec;
  logic [7:0]   cpu_irq;
  int ntests = 0, nfail = 0;

  always #2 clk = ~clk;

  sgi_dispatch u_dut (.clk, .rst_n, .online_cnt, .bus_cpu, .bus_wr, .bus_addr,
                      .bus_wide, .bus_wdata, .bus_rdata, .pend_vec, .cpu_irq);

  typedef struct packed {
    logic [2:0]  wc; logic [5:0] wa; logic ww; logic [31:0] wd;
    logic [2:0]  rc; logic [5:0] ra; logic rw; logic [31:0] er;
    logic [7:0]  ei; logic [3:0] req;
  } step_t;

  localparam int NSTEP = 15;
  localparam step_t STEPS [NSTEP] = '{
    '{3'd1, 6'h00, 1'b1, 32'h00050003, 3'd0, 6'h13, 1'b0, 32'h00000002, 8'h05, 4'd1},  // R1 explicit list
    '{3'd3, 6'h00, 1'b1, 32'h00F00004, 3'd4, 6'h24, 1'b0, 32'h00000000, 8'h05, 4'd1},  // R1 offline ignored
    '{3'd2, 6'h00, 1'b1, 32'h01000005, 3'd0, 6'h24, 1'b1, 32'h00000400, 8'h0F, 4'd2},  // R2 all but self
    '{3'd2, 6'h00, 1'b1, 32'h02FF0007, 3'd2, 6'h14, 1'b1, 32'h04000000, 8'h0F, 4'd3},  // R3 self only
    '{3'd0, 6'h00, 1'b1, 32'h03FF0009, 3'd1, 6'h19, 1'b0, 32'h00000000, 8'h0F, 4'd4},  // R4 reserved
    '{3'd3, 6'h00, 1'b1, 32'h00010003, 3'd0, 6'h23, 1'b0, 32'h0000000A, 8'h0F, 4'd5},  // R5 source OR
    '{3'd1, 6'h28, 1'b0, 32'hFFFFFF30, 3'd1, 6'h18, 1'b0, 32'h00000030, 8'h0F, 4'd9},  // R9 narrow lane
    '{3'd1, 6'h2D, 1'b1, 32'h80000001, 3'd1, 6'h1C, 1'b1, 32'h80000001, 8'h0F, 4'd9},  // R9 wide lanes
    '{3'd0, 6'h13, 1'b0, 32'h00000002, 3'd0, 6'h23, 1'b0, 32'h00000008, 8'h0F, 4'd7},  // R7 partial clear
    '{3'd0, 6'h14, 1'b1, 32'hFFFFFFFF, 3'd0, 6'h24, 1'b1, 32'h00000000, 8'h0F, 4'd7},  // R7 wide clear
    '{3'd0, 6'h13, 1'b0, 32'h00000008, 3'd0, 6'h13, 1'b0, 32'h00000000, 8'h0E, 4'd7},  // R7 last bit
    '{3'd0, 6'h22, 1'b0, 32'h00000000, 3'd0, 6'h22, 1'b0, 32'h00000000, 8'h0E, 4'd6},  // R6 zero byte
    '{3'd1, 6'h30, 1'b1, 32'hFFFFFFFF, 3'd1, 6'h00, 1'b1, 32'h00000000, 8'h0E, 4'd8},  // R8 unmapped, gen reads 0
    '{3'd2, 6'h23, 1'b0, 32'h00000040, 3'd0, 6'h23, 1'b0, 32'h00000000, 8'h0E, 4'd10}, // R10 other copy untouched
    '{3'd0, 6'h30, 1'b0, 32'h00000000, 3'd2, 6'h13, 1'b0, 32'h00000042, 8'h0E, 4'd6}   // R6 accumulated mask
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] c, input logic [5:0] a, input logic w, input logic [31:0] d);
    @(negedge clk);
    bus_cpu = c; bus_addr = a; bus_wide = w; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] c, input logic [5:0] a, input logic w, output logic [31:0] d);
    bus_cpu = c; bus_addr = a; bus_wide = w;
    #1 d = bus_rdata;
  endtask

  initial begin
    #(4 * 200000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(3'd0, 6'h20, 1'b1, d);
    chk("R12 reset irq", 64'(cpu_irq), 64'h0);
    chk("R12 reset pend", pend_vec[63:0], 64'h0);
    chk("R12 reset mask", 64'(d), 64'h0);

    for (int s = 0; s < NSTEP; s++) begin
      wr(STEPS[s].wc, STEPS[s].wa, STEPS[s].ww, STEPS[s].wd);
      rd(STEPS[s].rc, STEPS[s].ra, STEPS[s].rw, d);
      chk($sformatf("R%0d step %0d rdata", STEPS[s].req, s), 64'(d), 64'(STEPS[s].er));
      chk($sformatf("R%0d step %0d irq", STEPS[s].req, s), 64'(cpu_irq), 64'(STEPS[s].ei));
    end

    chk("R11 pend_vec low", pend_vec[63:0], 64'h0020_0088_9120_0000);
    chk("R11 pend_vec high", pend_vec[127:64], 64'h0);

    online_cnt = 4'd1;
    wr(3'd0, 6'h00, 1'b1, 32'h01FF0000);
    chk("R2 single cpu online", 64'(cpu_irq), 64'h0E);

    online_cnt = 4'd8;
    wr(3'd7, 6'h00, 1'b1, 32'h01000000);
    rd(3'd6, 6'h20, 1'b0, d);
    chk("R2 eight online irq", 64'(cpu_irq), 64'h7F);
    chk("R2 eight online mask", 64'(d), 64'h80);
    wr(3'd0, 6'h00, 1'b1, 32'h00800001);
    chk("R1 top target", 64'(cpu_irq), 64'hFF);

    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd(3'd6, 6'h20, 1'b0, d);
    chk("R12 rereset irq", 64'(cpu_irq), 64'h0);
    chk("R12 rereset pend", 64'(|pend_vec), 64'h0);
    chk("R12 rereset mask", 64'(d), 64'h0);

    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule